// File: doc/BRIEF.md
# Data Memory Operand Address Generator

This block turns the operand fields of a byte- or bit-oriented instruction into a 12-bit data memory address. It serves an 8-bit core whose data space is split into sixteen 256-byte banks. The core also has an optional extended mode, in which small operands become offsets from an index pointer.

The block holds two registers: a bank register and a 12-bit index pointer. The core loads them through write-enable ports, and the pointer is loaded as a high nibble and a low byte. To start a lookup, the core presents the instruction word together with a request strobe. One clock later the block returns the address, a 2-bit mode code and a valid flag. The address and mode code stay unchanged until the next request.

Top module: `opnd_addr_gen`

## Requirements
- R1: A synchronous reset clears the bank register, the index pointer and the valid flag. After reset, a banked lookup of operand f returns address f, and an indexed lookup returns address f.
- R2: `valid` is 1 in the cycle after a clock edge at which `req` was 1, and 0 after any edge at which `req` was 0.
- R3: When the access bit (instruction bit 8) is 1, the address is {bank, f}, where f is instruction bits 7:0. The mode code is 0. This holds whatever `ext_en` is.
- R4: When `ext_en` is 1, the access bit is 0 and f is 60h or above, the address is F00h + f and the mode code is 1.
- R5: When `ext_en` is 1, the access bit is 0 and f is 5Fh or below, the address is the index pointer plus f, taken modulo 4096, and the mode code is 2.
- R6: When `ext_en` is 0 and the access bit is 0, the mode code is 1. Operands 00h–5Fh give addresses 000h–05Fh, and operands 60h–FFh give F60h–FFFh.
- R7: `ptr_hi_we` loads pointer bits 11:8 and `ptr_lo_we` loads pointer bits 7:0, each independently of the other. A pointer write in the same cycle as a request is not seen by that request; it is seen by the next one.
- R8: `bank_we` loads the bank register. A bank write in the same cycle as a request is not seen by that request.
- R9: In a cycle without a request, `addr` and `mode` keep their previous values.
- R10: Instruction bits 15:9 (the opcode and the destination bit) have no effect on `addr` or `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_we | input | 1 | Load enable for the bank register |
| bank_din | input | 4 | New bank value |
| ptr_hi_we | input | 1 | Load enable for pointer bits 11:8 |
| ptr_hi_din | input | 4 | New pointer high nibble |
| ptr_lo_we | input | 1 | Load enable for pointer bits 7:0 |
| ptr_lo_din | input | 8 | New pointer low byte |
| ext_en | input | 1 | Extended indexed mode enable |
| req | input | 1 | Address request strobe |
| instr | input | 16 | Instruction word |
| addr | output | 12 | Effective data address |
| mode | output | 2 | 0 banked, 1 forced access, 2 indexed |
| valid | output | 1 | Result valid, one cycle after `req` |

## Verification
The bench builds the block with its default parameters: a 4-bit bank, an 8-bit operand and an access split at 60h. These values put the exact 5Fh/60h boundary within reach in both the extended and the plain mode. They also allow an index sum that wraps past FFFh, and they allow same-cycle pointer and bank writes against a pending request, to be checked against a model the bench computes itself.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int BANK_W    = 4,
  parameter int OFS_W     = 8,
  parameter int ACC_SPLIT = 96,
  parameter int A_BIT     = 8,
  parameter int INSTR_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bank_we,
  input  logic [BANK_W-1:0]         bank_din,
  input  logic                      ptr_hi_we,
  input  logic [BANK_W-1:0]         ptr_hi_din,
  input  logic                      ptr_lo_we,
  input  logic [OFS_W-1:0]          ptr_lo_din,
  input  logic                      ext_en,
  input  logic                      req,
  input  logic [INSTR_W-1:0]        instr,
  output logic [BANK_W+OFS_W-1:0]   addr,
  output logic [1:0]                mode,
  output logic                      valid
);
  localparam int ADDR_W = BANK_W + OFS_W;
  localparam logic [BANK_W-1:0] TOP_BANK = '1;
  localparam logic [BANK_W-1:0] LOW_BANK = '0;
  localparam logic [1:0] M_BANK = 2'd0;
  localparam logic [1:0] M_ACC  = 2'd1;
  localparam logic [1:0] M_IDX  = 2'd2;

  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [1:0]        mode_d;

  wire              acc_n = instr[A_BIT];
  wire [OFS_W-1:0]  f     = instr[OFS_W-1:0];
  wire              low   = int'(f) < ACC_SPLIT;
  wire [ADDR_W-1:0] idx   = ptr_q + {{BANK_W{1'b0}}, f};

  always_comb begin
    if (acc_n) begin
      addr_d = {bank_q, f};
      mode_d = M_BANK;
    end else if (ext_en && low) begin
      addr_d = idx;
      mode_d = M_IDX;
    end else begin
      addr_d = {low ? LOW_BANK : TOP_BANK, f};
      mode_d = M_ACC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      ptr_q  <= '0;
      valid  <= 1'b0;
      addr   <= '0;
      mode   <= M_BANK;
    end else begin
      if (bank_we)   bank_q               <= bank_din;
      if (ptr_hi_we) ptr_q[ADDR_W-1:OFS_W] <= ptr_hi_din;
      if (ptr_lo_we) ptr_q[OFS_W-1:0]     <= ptr_lo_din;
      valid <= req;
      if (req) begin
        addr <= addr_d;
        mode <= mode_d;
      end
    end
  end
endmodule

module opnd_addr_gen_chk #(
  parameter int BANK_W = 4,
  parameter int OFS_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req,
  input logic                    ext_en,
  input logic [15:0]             instr,
  input logic [BANK_W-1:0]       bank_q,
  input logic [BANK_W+OFS_W-1:0] addr,
  input logic [1:0]              mode,
  input logic                    valid
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req |=> valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req |=> !valid);
  a_r3_banked: assert property (@(posedge clk) disable iff (rst)
    (req && instr[8]) |=> (mode == 2'd0 && addr[BANK_W+OFS_W-1:OFS_W] == $past(bank_q)));
  a_r4_forced_top: assert property (@(posedge clk) disable iff (rst)
    (req && !instr[8] && ext_en && instr[7:0] >= 8'h60)
      |=> (mode == 2'd1 && addr == {4'hF, $past(instr[7:0])}));
  a_r5_indexed: assert property (@(posedge clk) disable iff (rst)
    (req && !instr[8] && ext_en && instr[7:0] < 8'h60) |=> mode == 2'd2);
  a_r6_plain_access: assert property (@(posedge clk) disable iff (rst)
    (req && !instr[8] && !ext_en) |=> (mode == 2'd1 && addr[7:0] == $past(instr[7:0])));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(addr) && $stable(mode)));
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst)
    valid |-> mode != 2'd3);
endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .ext_en(ext_en), .instr(instr),
  .bank_q(bank_q), .addr(addr), .mode(mode), .valid(valid)
);

// File: tb/sim_opnd_addr_gen.sv
module sim_opnd_addr_gen;
  logic        clk = 0;
  logic        rst, bank_we, ptr_hi_we, ptr_lo_we, ext_en, req;
  logic [3:0]  bank_din, ptr_hi_din;
  logic [7:0]  ptr_lo_din;
  logic [15:0] instr;
  logic [11:0] addr;
  logic [1:0]  mode;
  logic        valid;

  int nchk = 0, nfail = 0;
  logic [3:0]  m_bank;
  logic [11:0] m_ptr;

  always #5 clk = ~clk;

  opnd_addr_gen u0 (
    .clk(clk), .rst(rst), .bank_we(bank_we), .bank_din(bank_din),
    .ptr_hi_we(ptr_hi_we), .ptr_hi_din(ptr_hi_din), .ptr_lo_we(ptr_lo_we),
    .ptr_lo_din(ptr_lo_din), .ext_en(ext_en), .req(req), .instr(instr),
    .addr(addr), .mode(mode), .valid(valid)
  );

  task automatic check(input string tag, input logic [11:0] a_exp, input logic [1:0] m_exp,
                       input logic v_exp);
    nchk++;
    if (addr !== a_exp || mode !== m_exp || valid !== v_exp) begin
      nfail++;
      $display("FAIL %s: addr=%h mode=%0d valid=%b expected addr=%h mode=%0d valid=%b",
               tag, addr, mode, valid, a_exp, m_exp, v_exp);
    end
  endtask

  function automatic logic [13:0] model(input logic [15:0] ins, input logic ex);
    logic [7:0] f = ins[7:0];
    if (ins[8])              return {2'd0, m_bank, f};
    if (ex && f < 8'h60)     return {2'd2, m_ptr + {4'h0, f}};
    if (f < 8'h60)           return {2'd1, 4'h0, f};
    return {2'd1, 4'hF, f};
  endfunction

  task automatic idle();
    bank_we = 0; ptr_hi_we = 0; ptr_lo_we = 0; req = 0;
  endtask

  task automatic lookup(input string tag, input logic [15:0] ins, input logic ex);
    logic [13:0] e;
    @(negedge clk);
    instr = ins; ext_en = ex; req = 1;
    e = model(ins, ex);
    @(negedge clk);
    idle();
    check(tag, e[11:0], e[13:12], 1'b1);
  endtask

  task automatic set_bank(input logic [3:0] b);
    @(negedge clk); bank_we = 1; bank_din = b;
    @(negedge clk); idle(); m_bank = b;
  endtask

  task automatic set_ptr(input logic [11:0] p);
    @(negedge clk); ptr_hi_we = 1; ptr_hi_din = p[11:8]; ptr_lo_we = 1; ptr_lo_din = p[7:0];
    @(negedge clk); idle(); m_ptr = p;
  endtask

  task automatic t_reset();
    check("R1 reset outputs", 12'h000, 2'd0, 1'b0);
    lookup("R1 bank cleared", 16'h0142, 1'b0);
    lookup("R1 pointer cleared", 16'h0033, 1'b1);
  endtask

  task automatic t_valid();
    @(negedge clk);
    check("R2 valid drops", addr, mode, 1'b0);
  endtask

  task automatic t_banked();
    set_bank(4'h5);
    lookup("R3 banked ext off", 16'h013C, 1'b0);
    lookup("R3 banked ext on low f", 16'h0110, 1'b1);
    set_bank(4'hF);
    lookup("R3 banked top", 16'h01FF, 1'b1);
  endtask

  task automatic t_forced();
    lookup("R4 forced 60h", 16'h0060, 1'b1);
    lookup("R4 forced FFh", 16'h00FF, 1'b1);
  endtask

  task automatic t_indexed();
    set_ptr(12'h123);
    lookup("R5 indexed 5Fh", 16'h005F, 1'b1);
    lookup("R5 indexed 00h", 16'h0000, 1'b1);
    set_ptr(12'hFF0);
    lookup("R5 indexed wrap", 16'h0020, 1'b1);
  endtask

  task automatic t_plain();
    lookup("R6 plain 5Fh", 16'h005F, 1'b0);
    lookup("R6 plain 60h", 16'h0060, 1'b0);
    lookup("R6 plain 00h", 16'h0000, 1'b0);
  endtask

  task automatic t_ptr_load();
    logic [13:0] e;
    set_ptr(12'h200);
    @(negedge clk); ptr_lo_we = 1; ptr_lo_din = 8'h40;
    @(negedge clk); idle(); m_ptr = 12'h240;
    lookup("R7 low byte only", 16'h0001, 1'b1);
    @(negedge clk); ptr_hi_we = 1; ptr_hi_din = 4'h7;
    @(negedge clk); idle(); m_ptr = 12'h740;
    lookup("R7 high nibble only", 16'h0002, 1'b1);
    @(negedge clk);
    ptr_lo_we = 1; ptr_lo_din = 8'h00; instr = 16'h0005; ext_en = 1; req = 1;
    e = model(16'h0005, 1'b1);
    @(negedge clk); idle(); m_ptr = 12'h700;
    check("R7 same-cycle write hidden", e[11:0], e[13:12], 1'b1);
    lookup("R7 write seen next", 16'h0005, 1'b1);
  endtask

  task automatic t_bank_load();
    logic [13:0] e;
    set_bank(4'h2);
    @(negedge clk);
    bank_we = 1; bank_din = 4'h9; instr = 16'h0177; ext_en = 0; req = 1;
    e = model(16'h0177, 1'b0);
    @(negedge clk); idle(); m_bank = 4'h9;
    check("R8 same-cycle bank hidden", e[11:0], e[13:12], 1'b1);
    lookup("R8 bank seen next", 16'h0177, 1'b0);
  endtask

  task automatic t_hold();
    lookup("R9 setup", 16'h0188, 1'b0);
    @(negedge clk); instr = 16'h0012; ext_en = 1;
    @(negedge clk);
    check("R9 hold without req", {4'h9, 8'h88}, 2'd0, 1'b0);
  endtask

  task automatic t_opcode();
    lookup("R10 opcode bits banked", 16'hFF55, 1'b0);
    lookup("R10 opcode bits indexed", 16'hFE10, 1'b1);
    lookup("R10 opcode bits forced", 16'h26A0, 1'b1);
  endtask

  initial begin
    idle(); rst = 1; ext_en = 0; instr = 0; bank_din = 0; ptr_hi_din = 0; ptr_lo_din = 0;
    m_bank = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_valid();
    t_banked();
    t_forced();
    t_indexed();
    t_plain();
    t_ptr_load();
    t_bank_load();
    t_hold();
    t_opcode();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule